// File: doc/BRIEF.md
# Processor System Control Register Unit

This unit holds three system registers of a processor core: the mode-control word, the last page-fault linear address and the page-directory base. It also makes the decisions that depend on them. Software writes the registers with a move instruction. A clear-task-switched command drops the task-switched flag. A task-switch event sets that flag and loads a new directory base. A page-fault event records the address that faulted.

From the stored flags the unit decides whether a floating-point or wait instruction must take a device-not-available trap. It rejects a mode write that would enable paging without protection and raises a general-protection fault. It asks the translation buffer to flush when the directory base really changes. It reports the current operating mode to the rest of the core. All three pulse outputs are registered, so each goes high for one cycle, in the cycle after the event that causes it.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the mode word reads zero except bit 4, which holds the value of the coprocessor-protocol strap. The fault-address and directory-base registers read zero, and every pulse output is low.
- R2: The read port is combinational and is selected by a 2-bit index. Index 0 is the mode word, 1 reads zero and ignores writes, 2 is the fault address and 3 is the directory base.
- R3: The mode word stores only bits 0 (protect enable), 1 (monitor coprocessor), 2 (emulate), 3 (task switched), 4 (coprocessor protocol), 5 (numeric error) and 31 (paging enable). All other bits read as zero whatever is written.
- R4: A floating-point issue makes the trap output pulse one cycle later if the emulate bit or the task-switched bit is 1.
- R5: A wait issue makes the trap output pulse one cycle later only when the monitor and task-switched bits are both 1. The emulate bit has no effect on it.
- R6: A task switch sets the task-switched bit and a clear command clears it. When both occur in the same cycle, the bit ends up set. A task switch has priority over a same-cycle move write to that bit.
- R7: A mode write with bit 31 set and bit 0 clear leaves the mode word unchanged and makes the fault output pulse one cycle later.
- R8: The 2-bit mode output is {paging, protect}: 00 means real mode, 01 means protected mode without paging, and 11 means paged protected mode.
- R9: The directory base keeps bits 31..12 and reads zeros in bits 11..0. It can be loaded whatever the paging bit is.
- R10: A move write to the directory base always pulses the flush output one cycle later. A task switch pulses it only when the new bits 31..12 differ from the stored ones. The task-switch base has priority over a same-cycle move write.
- R11: A page-fault event stores the full 32-bit address in the fault-address register and has priority over a same-cycle move write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_fpu32 | input | 1 | Reset value of mode bit 4 |
| wr_en | input | 1 | Move-instruction write strobe |
| wr_idx | input | 2 | Register index of the write |
| wr_data | input | 32 | Write data |
| clr_ts | input | 1 | Clear the task-switched bit |
| task_sw | input | 1 | Task-switch event |
| task_base | input | 32 | Directory base carried by the task switch |
| pf_valid | input | 1 | Page-fault event |
| pf_addr | input | 32 | Faulting linear address |
| fp_issue | input | 1 | A floating-point instruction is issuing |
| wait_issue | input | 1 | A wait instruction is issuing |
| rd_idx | input | 2 | Register index of the read |
| rd_data | output | 32 | Read data |
| mode | output | 2 | Operating mode {paging, protect} |
| dna_trap | output | 1 | Device-not-available pulse |
| gp_fault | output | 1 | General-protection pulse for a rejected mode write |
| tlb_flush | output | 1 | Translation-buffer flush pulse |

## Verification
The bench steps all eight emulate/monitor/task-switched combinations for both instruction kinds. A design that swapped the roles of the emulate and monitor bits would trap wait instructions under emulation, or let floating-point work run with a stale context. It writes paging-without-protection and then reads the mode word back, which exposes a unit that faults but still commits the bad value. It also loads the same directory base through a task switch, with different low bits each time, to catch flushes on every switch or comparisons that include the discarded low bits. Same-cycle collisions (clear against switch, fault against move write) and a long random run expose wrong priorities.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int XLEN      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strap_fpu32,
  input  logic            wr_en,
  input  logic [1:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            clr_ts,
  input  logic            task_sw,
  input  logic [XLEN-1:0] task_base,
  input  logic            pf_valid,
  input  logic [XLEN-1:0] pf_addr,
  input  logic            fp_issue,
  input  logic            wait_issue,
  input  logic [1:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic [1:0]      mode,
  output logic            dna_trap,
  output logic            gp_fault,
  output logic            tlb_flush
);
  localparam int BW = XLEN - PAGE_BITS;

  logic pe, mp, em, ts, et, ne, pg;
  logic [XLEN-1:0] fault_q;
  logic [BW-1:0]   base_q;

  wire mode_wr  = wr_en && wr_idx == 2'd0;
  wire mode_bad = mode_wr && wr_data[XLEN-1] && !wr_data[0];
  wire mode_ok  = mode_wr && !mode_bad;
  wire base_wr  = wr_en && wr_idx == 2'd3;
  wire fault_wr = wr_en && wr_idx == 2'd2;
  wire base_new = task_base[XLEN-1:PAGE_BITS] != base_q;

  wire [XLEN-1:0] mode_word = {pg, {(XLEN-7){1'b0}}, ne, et, ts, em, mp, pe};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {pe, mp, em, ts, ne, pg} <= '0;
      et        <= strap_fpu32;
      fault_q   <= '0;
      base_q    <= '0;
      dna_trap  <= 1'b0;
      gp_fault  <= 1'b0;
      tlb_flush <= 1'b0;
    end else begin
      if (mode_ok) begin
        {ne, et, ts, em, mp, pe} <= wr_data[5:0];
        pg <= wr_data[XLEN-1];
      end
      if (clr_ts)  ts <= 1'b0;
      if (task_sw) ts <= 1'b1;

      if (task_sw)      base_q <= task_base[XLEN-1:PAGE_BITS];
      else if (base_wr) base_q <= wr_data[XLEN-1:PAGE_BITS];

      if (pf_valid)      fault_q <= pf_addr;
      else if (fault_wr) fault_q <= wr_data;

      dna_trap  <= (fp_issue && (em || ts)) || (wait_issue && mp && ts);
      gp_fault  <= mode_bad;
      tlb_flush <= base_wr || (task_sw && base_new);
    end
  end

  assign mode = {pg, pe};

  always_comb begin
    case (rd_idx)
      2'd0:    rd_data = mode_word;
      2'd2:    rd_data = fault_q;
      2'd3:    rd_data = {base_q, {PAGE_BITS{1'b0}}};
      default: rd_data = '0;
    endcase
  end

  AST_FP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fp_issue && (em || ts) |=> dna_trap); // R4
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wait_issue && !fp_issue && !(mp && ts) |=> !dna_trap); // R5
  AST_TS_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> ts); // R6
  AST_BAD_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad && !task_sw && !clr_ts |=> $stable(mode_word) && gp_fault); // R7
  AST_NO_PG_WITHOUT_PE: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b10); // R8
  AST_SAME_BASE_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw && !base_wr && !base_new |=> !tlb_flush); // R10
  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> fault_q == $past(pf_addr)); // R11
endmodule

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_fpu32 = 1'b1;
  logic wr_en = 0, clr_ts = 0, task_sw = 0, pf_valid = 0, fp_issue = 0, wait_issue = 0;
  logic [1:0] wr_idx = 0, rd_idx = 0;
  logic [31:0] wr_data = 0, task_base = 0, pf_addr = 0;
  logic [31:0] rd_data;
  logic [1:0] mode;
  logic dna_trap, gp_fault, tlb_flush;

  int vectors = 0, errors = 0;
  logic [31:0] m_cr0, m_cr2, m_cr3;
  logic m_dna, m_gp, m_fl;

  always #5 clk = ~clk;

  sysctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .strap_fpu32(strap_fpu32),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .clr_ts(clr_ts), .task_sw(task_sw), .task_base(task_base),
    .pf_valid(pf_valid), .pf_addr(pf_addr),
    .fp_issue(fp_issue), .wait_issue(wait_issue),
    .rd_idx(rd_idx), .rd_data(rd_data), .mode(mode),
    .dna_trap(dna_trap), .gp_fault(gp_fault), .tlb_flush(tlb_flush)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [1:0] idx);
    case (idx)
      2'd0: return m_cr0;
      2'd2: return m_cr2;
      2'd3: return m_cr3;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare_all();
    chk("R2 read port", rd_data, model_rd(rd_idx));
    chk("R8 mode", {30'h0, mode}, {30'h0, m_cr0[31], m_cr0[0]});
    chk("R4/R5 trap", {31'h0, dna_trap}, {31'h0, m_dna});
    chk("R7 fault", {31'h0, gp_fault}, {31'h0, m_gp});
    chk("R10 flush", {31'h0, tlb_flush}, {31'h0, m_fl});
  endtask

  task automatic model_step();
    logic [31:0] n0;
    logic wrm, bad;
    n0  = m_cr0;
    wrm = wr_en && wr_idx == 2'd0;
    bad = wrm && wr_data[31] && !wr_data[0];
    m_dna = (fp_issue && (m_cr0[2] || m_cr0[3])) || (wait_issue && m_cr0[1] && m_cr0[3]);
    m_gp  = bad;
    m_fl  = (wr_en && wr_idx == 2'd3) || (task_sw && ((task_base & 32'hFFFFF000) != m_cr3));
    if (wrm && !bad) n0 = wr_data & 32'h8000003F;
    if (clr_ts) n0[3] = 1'b0;
    if (task_sw) n0[3] = 1'b1;
    m_cr0 = n0;
    if (task_sw) m_cr3 = task_base & 32'hFFFFF000;
    else if (wr_en && wr_idx == 2'd3) m_cr3 = wr_data & 32'hFFFFF000;
    if (pf_valid) m_cr2 = pf_addr;
    else if (wr_en && wr_idx == 2'd2) m_cr2 = wr_data;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 0; clr_ts = 0; task_sw = 0; pf_valid = 0; fp_issue = 0; wait_issue = 0;
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk);
    strap_fpu32 = strap;
    rst_n = 1'b0;
    m_cr0 = {27'h0, strap, 4'h0}; m_cr2 = 0; m_cr3 = 0;
    m_dna = 0; m_gp = 0; m_fl = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin // R1: reset values on every index
      rd_idx = i[1:0];
      #1 compare_all();
    end
  endtask

  task automatic wr(logic [1:0] idx, logic [31:0] d);
    wr_en = 1; wr_idx = idx; wr_data = d;
    tick();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    rd_idx = 0;
    wr(2'd0, 32'hFFFF_FFFF);            // R3 reserved bits dropped, R8 mode 11
    wr(2'd0, 32'h8000_0000);            // R7 rejected, word held
    wr(2'd0, 32'h0000_0001);            // R8 mode 01
    wr(2'd0, 32'h0000_0000);            // R8 mode 00
    rd_idx = 1; wr(2'd1, 32'hDEAD_BEEF); // R2 index 1 reads zero
    for (int c = 0; c < 8; c++) begin   // R4 R5 all em/mp/ts combos
      rd_idx = 0;
      wr(2'd0, {28'h0, c[2:0], 1'b1});
      fp_issue = 1; tick();
      wait_issue = 1; tick();
    end
    wr(2'd0, 32'h1);
    task_sw = 1; task_base = 32'h0; tick();  // R6 set
    clr_ts = 1; tick();                       // R6 clear
    clr_ts = 1; task_sw = 1; tick();          // R6 switch wins
    rd_idx = 3;
    wr(2'd3, 32'h1234_5ABC);                  // R9 low bits zero, R10 flush
    task_sw = 1; task_base = 32'h1234_5FFF; tick(); // R10 same base, no flush
    task_sw = 1; task_base = 32'h8765_4000; tick(); // R10 new base, flush
    wr_en = 1; wr_idx = 3; wr_data = 32'h1111_1000;
    task_sw = 1; task_base = 32'h2222_2000; tick(); // R10 switch wins
    rd_idx = 2;
    pf_valid = 1; pf_addr = 32'hCAFE_F00D; tick();  // R11 capture
    pf_valid = 1; pf_addr = 32'h0BAD_0001;
    wr_en = 1; wr_idx = 2; wr_data = 32'h5555_5555; tick(); // R11 fault wins
    wr(2'd2, 32'h7777_7777);
    for (int n = 0; n < 4000; n++) begin
      rd_idx = 2'($urandom);
      wr_en = ($urandom % 3) == 0; wr_idx = 2'($urandom);
      wr_data = $urandom;
      if ($urandom % 2) wr_data[31] = wr_data[0];
      clr_ts = ($urandom % 5) == 0; task_sw = ($urandom % 6) == 0;
      task_base = ($urandom % 2) ? (m_cr3 | 32'($urandom % 4096)) : $urandom;
      pf_valid = ($urandom % 7) == 0; pf_addr = $urandom;
      fp_issue = ($urandom % 3) == 0; wait_issue = ($urandom % 3) == 0;
      tick();
    end
    do_reset(1'b0);                     // R1 strap low
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule